// File: doc/BRIEF.md
# Indexed Interrupt Redirection Unit

This block routes up to 24 external interrupt pins to processors as delivery messages. Every pin has a 64-bit redirection entry. The entry selects the pin's polarity, its trigger mode and its mask. It also supplies the fields of the message the pin produces: vector, delivery mode, destination mode and destination. A host reaches these entries over a plain 32-bit register bus through two addresses only. The first holds an index and the second is a data window onto the indexed 32-bit word.

Messages leave through a valid/ready port, one message per accepted handshake. Pins that are waiting are served lowest-numbered first. Each entry exposes two read-only flags. One says that a message is waiting to be sent. The other, for level-triggered pins, says that a message was delivered and has not yet been closed by an end-of-interrupt (EOI) carrying the entry's vector. While this second flag is set, the pin is not delivered again.

Top module: `irq_redirect_unit`

## Requirements
- R1: Bus byte offset 0x00 is the index register, which reads back its 8-bit value. Bus offset 0x10 is the data window onto the word that the index selects. Any other offset reads zero and ignores writes.
- R2: Index 0x00 is the unit identifier, with 4 writable bits at 27:24 and all other bits reading zero. Index 0x02 (arbitration) reads the same value. Index 0x01 reads version 0x21 in bits 7:0 and the highest entry number (23) in bits 23:16.
- R3: Entry n has its low word at index 0x10+2n and its high word at 0x11+2n. The low word holds: vector 7:0, delivery mode 10:8, logical destination 11, waiting status 12 (read-only), active-low 13, remote flag 14 (read-only), level trigger 15 and mask 16. Bits 31:17 read zero. The high word holds the destination in 31:24, and its other bits read zero.
- R4: After reset every entry reads 0x00010000 low and 0x00000000 high, and no message is offered.
- R5: On an unmasked edge-triggered entry, a transition of the pin into its asserted state produces exactly one message carrying the entry's vector, delivery mode, destination mode and destination, with the level flag 0. An edge that arrives while the entry is masked is dropped, and unmasking later produces nothing.
- R6: With active-low set, the pin's low state counts as asserted.
- R7: The waiting status bit is 1 from the time a message is queued until its handshake completes, and 0 after that.
- R8: A level-triggered entry sets its remote flag when its message is accepted, and the message carries the level flag 1. It sends nothing further while the flag is set. An EOI with a different vector leaves the flag alone. An EOI with the entry's vector clears the flag, and if the pin is still asserted the message is sent again.
- R9: Entries in delivery mode 100 (NMI) or 101 (INIT) behave as edge-triggered even with the trigger bit set: level flag 0, the remote flag is never set, and a held pin sends one message.
- R10: When several pins wait, the lowest-numbered pin is offered first, and each accepted handshake removes exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| irqPins | input | 24 | Raw interrupt pins |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Receiver accepts the message |
| msgVector | output | 8 | Message vector |
| msgDelMode | output | 3 | Message delivery mode |
| msgDestLogical | output | 1 | 1 = logical destination |
| msgDest | output | 8 | Destination |
| msgLevel | output | 1 | 1 = level-triggered delivery |
| eoiValid | input | 1 | EOI message strobe |
| eoiVector | input | 8 | Vector carried by the EOI |

## Verification
Directed patterns cover the separate triggering paths. An active-high edge pin against a masked one shows that edges are dropped rather than held. An active-low pin shows that polarity is applied before edge detection. A held level pin is run through a wrong-vector EOI and then a matching one, which separates gating by the remote flag from plain re-sending. A held NMI pin with its level bit set shows the mode override. Two pins raised in the same cycle expose the service order. Random programming of entries (vector, mode, destination) on random pins then checks that every message field is taken from the entry of the pin that fired.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [2:0] DM_NMI  = 3'b100;
  localparam logic [2:0] DM_INIT = 3'b101;

  typedef struct packed {
    logic       mask;
    logic       trigLevel;
    logic       activeLow;
    logic       destLogical;
    logic [2:0] delMode;
    logic [7:0] vector;
    logic [7:0] dest;
  } redirEntry_t;

  typedef struct packed {
    logic        wrEntryLo;
    logic        wrEntryHi;
    logic [7:0]  entrySel;
    logic        fire;
    logic [7:0]  firePin;
    logic        eoi;
    logic [7:0]  eoiVector;
    logic [31:0] wrData;
  } ctrlStrobe_t;

  function automatic redirEntry_t entryResetValue();
    redirEntry_t e;
    e      = '0;
    e.mask = 1'b1;
    return e;
  endfunction

endpackage

// File: rtl/redir_datapath.sv
module redir_datapath
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  ctrlStrobe_t         strobe,
  output logic [NUM_PINS-1:0] pendingVec,
  output logic [31:0]         rdLoWord,
  output logic [31:0]         rdHiWord,
  output redirEntry_t         fireEntry,
  output logic                fireLevel
);

  redirEntry_t         entries [NUM_PINS];
  logic [NUM_PINS-1:0] pinReg;
  logic [NUM_PINS-1:0] assertedPrev;
  logic [NUM_PINS-1:0] remoteFlag;
  logic [NUM_PINS-1:0] asserted;
  logic [NUM_PINS-1:0] effLevel;
  logic [NUM_PINS-1:0] sentNow;
  logic [NUM_PINS-1:0] eoiHit;

  always_ff @(posedge clk) begin
    if (!rstN) pinReg <= '0;
    else       pinReg <= pinsIn;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign asserted[i] = pinReg[i] ^ entries[i].activeLow;
    assign effLevel[i] = entries[i].trigLevel &&
                         (entries[i].delMode != DM_NMI) &&
                         (entries[i].delMode != DM_INIT);
    assign sentNow[i]  = strobe.fire && (strobe.firePin == 8'(i));
    assign eoiHit[i]   = strobe.eoi && (strobe.eoiVector == entries[i].vector);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[i]      <= entryResetValue();
        pendingVec[i]   <= 1'b0;
        remoteFlag[i]   <= 1'b0;
        assertedPrev[i] <= 1'b0;
      end else begin
        if (strobe.wrEntryLo && strobe.entrySel == 8'(i)) begin
          entries[i].vector      <= strobe.wrData[7:0];
          entries[i].delMode     <= strobe.wrData[10:8];
          entries[i].destLogical <= strobe.wrData[11];
          entries[i].activeLow   <= strobe.wrData[13];
          entries[i].trigLevel   <= strobe.wrData[15];
          entries[i].mask        <= strobe.wrData[16];
        end
        if (strobe.wrEntryHi && strobe.entrySel == 8'(i))
          entries[i].dest <= strobe.wrData[31:24];

        if (effLevel[i])
          pendingVec[i] <= asserted[i] && !entries[i].mask &&
                           !remoteFlag[i] && !sentNow[i];
        else
          pendingVec[i] <= (pendingVec[i] && !sentNow[i]) ||
                           (asserted[i] && !assertedPrev[i] && !entries[i].mask);

        if (sentNow[i] && effLevel[i]) remoteFlag[i] <= 1'b1;
        else if (eoiHit[i])            remoteFlag[i] <= 1'b0;

        assertedPrev[i] <= asserted[i];
      end
    end

    // Masked entry with nothing queued must not queue anything (R5)
    p_masked_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
      (entries[i].mask && !pendingVec[i]) |=> !pendingVec[i]);

    // Remote flag blocks level re-delivery (R8)
    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (remoteFlag[i] && effLevel[i]) |=> !pendingVec[i]);

    // Accepted level message raises the remote flag (R8)
    p_remote_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      (sentNow[i] && effLevel[i]) |=> remoteFlag[i]);
  end

  always_comb begin
    rdLoWord  = '0;
    rdHiWord  = '0;
    fireEntry = entryResetValue();
    fireLevel = 1'b0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (strobe.entrySel == 8'(k)) begin
        rdLoWord = {15'b0, entries[k].mask, entries[k].trigLevel, remoteFlag[k],
                    entries[k].activeLow, pendingVec[k], entries[k].destLogical,
                    entries[k].delMode, entries[k].vector};
        rdHiWord = {entries[k].dest, 24'b0};
      end
      if (strobe.firePin == 8'(k)) begin
        fireEntry = entries[k];
        fireLevel = effLevel[k];
      end
    end
  end

endmodule

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pendingVec,
  input  logic [31:0]         rdLoWord,
  input  logic [31:0]         rdHiWord,
  input  logic                msgReady,
  output logic                msgValid,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output ctrlStrobe_t         strobe
);

  localparam logic [7:0] ADDR_INDEX   = 8'h00;
  localparam logic [7:0] ADDR_WINDOW  = 8'h10;
  localparam logic [7:0] IDX_ID       = 8'h00;
  localparam logic [7:0] IDX_VER      = 8'h01;
  localparam logic [7:0] IDX_ARB      = 8'h02;
  localparam logic [7:0] IDX_FIRST    = 8'h10;
  localparam logic [7:0] IDX_LAST     = 8'(16 + 2 * NUM_PINS - 1);
  localparam logic [7:0] MAX_ENTRY    = 8'(NUM_PINS - 1);

  logic [7:0] indexReg;
  logic [3:0] idReg;
  logic       entryHit;
  logic       winWrite;
  logic [7:0] firePin;
  logic       anyPend;

  assign entryHit = (indexReg >= IDX_FIRST) && (indexReg <= IDX_LAST);
  assign winWrite = busWrEn && (busAddr == ADDR_WINDOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      idReg    <= '0;
    end else begin
      if (busWrEn && busAddr == ADDR_INDEX) indexReg <= busWrData[7:0];
      if (winWrite && indexReg == IDX_ID)  idReg    <= busWrData[27:24];
    end
  end

  always_comb begin
    firePin = '0;
    anyPend = 1'b0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (pendingVec[k]) begin
        firePin = 8'(k);
        anyPend = 1'b1;
      end
    end
  end

  assign msgValid = anyPend;

  always_comb begin
    strobe           = '0;
    strobe.entrySel  = 8'((indexReg - IDX_FIRST) >> 1);
    strobe.wrEntryLo = winWrite && entryHit && !indexReg[0];
    strobe.wrEntryHi = winWrite && entryHit &&  indexReg[0];
    strobe.wrData    = busWrData;
    strobe.fire      = anyPend && msgReady;
    strobe.firePin   = firePin;
    strobe.eoi       = eoiValid;
    strobe.eoiVector = eoiVector;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_INDEX) begin
      busRdData = {24'b0, indexReg};
    end else if (busAddr == ADDR_WINDOW) begin
      if (indexReg == IDX_ID || indexReg == IDX_ARB)
        busRdData = {4'b0, idReg, 24'b0};
      else if (indexReg == IDX_VER)
        busRdData = {8'b0, MAX_ENTRY, 8'b0, VERSION};
      else if (entryHit)
        busRdData = indexReg[0] ? rdHiWord : rdLoWord;
    end
  end

  // Offered pin is waiting and no lower pin waits (R10)
  logic [NUM_PINS-1:0] lowerMask;
  assign lowerMask = ({{(NUM_PINS-1){1'b0}}, 1'b1} << firePin) - 1'b1;

  p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (pendingVec[firePin] && ((pendingVec & lowerMask) == '0)));

  // A completed handshake removes the served pin's request (R7)
  p_served_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !pendingVec[0]) |=> !pendingVec[$past(firePin)]
      || !$stable(pendingVec));

endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [7:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] irqPins,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgVector,
  output logic [2:0]          msgDelMode,
  output logic                msgDestLogical,
  output logic [7:0]          msgDest,
  output logic                msgLevel,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector
);

  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] pendingVec;
  logic [31:0]         rdLoWord;
  logic [31:0]         rdHiWord;
  redirEntry_t         fireEntry;
  logic                fireLevel;

  redir_ctrl #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData),
    .pendingVec(pendingVec), .rdLoWord(rdLoWord), .rdHiWord(rdHiWord),
    .msgReady(msgReady), .msgValid(msgValid),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .strobe(strobe)
  );

  redir_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(irqPins), .strobe(strobe),
    .pendingVec(pendingVec), .rdLoWord(rdLoWord), .rdHiWord(rdHiWord),
    .fireEntry(fireEntry), .fireLevel(fireLevel)
  );

  assign msgVector      = fireEntry.vector;
  assign msgDelMode     = fireEntry.delMode;
  assign msgDestLogical = fireEntry.destLogical;
  assign msgDest        = fireEntry.dest;
  assign msgLevel       = fireLevel;

endmodule

// File: tb/sim_irq_redirect_unit.sv
module sim_irq_redirect_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [23:0] irqPins = '0;
  logic        msgValid;
  logic        msgReady = 1'b0;
  logic [7:0]  msgVector;
  logic [2:0]  msgDelMode;
  logic        msgDestLogical;
  logic [7:0]  msgDest;
  logic        msgLevel;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_unit u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqPins(irqPins),
    .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector),
    .msgDelMode(msgDelMode), .msgDestLogical(msgDestLogical), .msgDest(msgDest),
    .msgLevel(msgLevel), .eoiValid(eoiValid), .eoiVector(eoiVector)
  );

  function automatic logic [31:0] loWord(logic [7:0] vec, logic [2:0] mode,
      logic logical, logic waiting, logic low, logic remote, logic level, logic mask);
    return {15'b0, mask, level, remote, low, waiting, logical, mode, vec};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr;
    #1 data = busRdData;
  endtask

  task automatic entryWrite(int n, logic [31:0] lo, logic [31:0] hi);
    busWrite(8'h00, 32'(8'h10 + 2 * n));
    busWrite(8'h10, lo);
    busWrite(8'h00, 32'(8'h11 + 2 * n));
    busWrite(8'h10, hi);
  endtask

  task automatic entryReadLo(int n, output logic [31:0] data);
    busWrite(8'h00, 32'(8'h10 + 2 * n));
    busRead(8'h10, data);
  endtask

  task automatic waitValid(int limit, output logic seen);
    seen = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (msgValid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic accept();
    @(negedge clk); msgReady = 1'b1;
    @(negedge clk); msgReady = 1'b0;
  endtask

  task automatic sendEoi(logic [7:0] vec);
    @(negedge clk); eoiValid = 1'b1; eoiVector = vec;
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic        seen;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 reset state
    check("R4 offered after reset", {31'b0, msgValid}, 0);
    entryReadLo(0, rd);
    check("R4 entry0 low", rd, 32'h0001_0000);
    busWrite(8'h00, 32'h11); busRead(8'h10, rd);
    check("R4 entry0 high", rd, 0);

    // R1 index readback and stray offset
    busWrite(8'h00, 32'h0000_0137);
    busRead(8'h00, rd);
    check("R1 index readback", rd, 32'h37);
    busWrite(8'h20, 32'hFFFF_FFFF);
    busRead(8'h20, rd);
    check("R1 stray offset", rd, 0);

    // R2 identifier, version, arbitration
    busWrite(8'h00, 0); busWrite(8'h10, 32'hFFFF_FFFF);
    busRead(8'h10, rd);
    check("R2 id", rd, 32'h0F00_0000);
    busWrite(8'h00, 2); busRead(8'h10, rd);
    check("R2 arbitration", rd, 32'h0F00_0000);
    busWrite(8'h00, 1); busRead(8'h10, rd);
    check("R2 version", rd, {8'h00, 8'd23, 8'h00, 8'h21});

    // R3 layout: read-only and reserved bits
    entryWrite(5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    entryReadLo(5, rd);
    check("R3 low writable bits", rd, loWord(8'hFF, 3'h7, 1, 0, 1, 0, 1, 1));
    busWrite(8'h00, 32'h1B); busRead(8'h10, rd);
    check("R3 high word", rd, 32'hFF00_0000);
    entryWrite(5, 32'h0001_0000, 0);

    // R5 edge delivery
    entryWrite(3, loWord(8'h40, 3'h0, 0, 0, 0, 0, 0, 0), 32'h0700_0000);
    @(negedge clk); irqPins[3] = 1'b1;
    waitValid(8, seen);
    check("R5 edge offered", {31'b0, seen}, 1);
    check("R5 vector", {24'b0, msgVector}, 32'h40);
    check("R5 dest", {24'b0, msgDest}, 32'h07);
    check("R5 level flag", {31'b0, msgLevel}, 0);
    entryReadLo(3, rd);
    check("R7 waiting bit set", rd, loWord(8'h40, 0, 0, 1, 0, 0, 0, 0));
    accept();
    entryReadLo(3, rd);
    check("R7 waiting bit cleared", rd, loWord(8'h40, 0, 0, 0, 0, 0, 0, 0));
    waitValid(6, seen);
    check("R5 held edge pin sends once", {31'b0, seen}, 0);
    @(negedge clk); irqPins[3] = 1'b0;

    // R5 masked edge dropped
    entryWrite(3, loWord(8'h40, 0, 0, 0, 0, 0, 0, 1), 0);
    @(negedge clk); irqPins[3] = 1'b1;
    repeat (4) @(negedge clk);
    irqPins[3] = 1'b0;
    repeat (3) @(negedge clk);
    entryWrite(3, loWord(8'h40, 0, 0, 0, 0, 0, 0, 0), 0);
    waitValid(6, seen);
    check("R5 masked edge dropped", {31'b0, seen}, 0);

    // R6 active-low pin
    @(negedge clk); irqPins[4] = 1'b1;
    entryWrite(4, loWord(8'h51, 3'h1, 1, 0, 1, 0, 0, 0), 32'h2A00_0000);
    waitValid(4, seen);
    check("R6 idle high is deasserted", {31'b0, seen}, 0);
    @(negedge clk); irqPins[4] = 1'b0;
    waitValid(8, seen);
    check("R6 low edge offered", {31'b0, seen}, 1);
    check("R6 vector", {24'b0, msgVector}, 32'h51);
    check("R6 mode/logical", {28'b0, msgDelMode, msgDestLogical}, {28'b0, 3'h1, 1'b1});
    accept();
    entryWrite(4, 32'h0001_0000, 0);
    @(negedge clk); irqPins[4] = 1'b0;

    // R8 level with remote flag and EOI
    entryWrite(6, loWord(8'h66, 0, 0, 0, 0, 0, 1, 0), 32'h0100_0000);
    @(negedge clk); irqPins[6] = 1'b1;
    waitValid(8, seen);
    check("R8 level offered", {31'b0, seen}, 1);
    check("R8 level flag", {31'b0, msgLevel}, 1);
    accept();
    entryReadLo(6, rd);
    check("R8 remote set", rd, loWord(8'h66, 0, 0, 0, 0, 1, 1, 0));
    waitValid(6, seen);
    check("R8 no resend while remote", {31'b0, seen}, 0);
    sendEoi(8'h67);
    waitValid(6, seen);
    check("R8 foreign EOI ignored", {31'b0, seen}, 0);
    entryReadLo(6, rd);
    check("R8 remote kept", rd, loWord(8'h66, 0, 0, 0, 0, 1, 1, 0));
    sendEoi(8'h66);
    waitValid(8, seen);
    check("R8 resend after EOI", {31'b0, seen}, 1);
    check("R8 resend vector", {24'b0, msgVector}, 32'h66);
    accept();
    @(negedge clk); irqPins[6] = 1'b0;
    sendEoi(8'h66);
    waitValid(6, seen);
    check("R8 deasserted no resend", {31'b0, seen}, 0);
    entryReadLo(6, rd);
    check("R8 remote cleared", rd, loWord(8'h66, 0, 0, 0, 0, 0, 1, 0));

    // R9 NMI with level bit behaves as edge
    entryWrite(7, loWord(8'h10, 3'h4, 0, 0, 0, 0, 1, 0), 0);
    @(negedge clk); irqPins[7] = 1'b1;
    waitValid(8, seen);
    check("R9 nmi offered", {31'b0, seen}, 1);
    check("R9 level flag", {31'b0, msgLevel}, 0);
    accept();
    entryReadLo(7, rd);
    check("R9 remote stays 0", rd, loWord(8'h10, 3'h4, 0, 0, 0, 0, 1, 0));
    waitValid(6, seen);
    check("R9 held nmi sends once", {31'b0, seen}, 0);
    @(negedge clk); irqPins[7] = 1'b0;
    entryWrite(7, 32'h0001_0000, 0);

    // R10 lowest pin first
    entryWrite(2, loWord(8'h22, 0, 0, 0, 0, 0, 0, 0), 0);
    entryWrite(9, loWord(8'h99, 0, 0, 0, 0, 0, 0, 0), 0);
    @(negedge clk); irqPins[2] = 1'b1; irqPins[9] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 first vector", {24'b0, msgVector}, 32'h22);
    accept();
    check("R10 second vector", {24'b0, msgVector}, 32'h99);
    accept();
    check("R10 drained", {31'b0, msgValid}, 0);
    @(negedge clk); irqPins = '0;
    entryWrite(2, 32'h0001_0000, 0);
    entryWrite(9, 32'h0001_0000, 0);
    entryWrite(3, 32'h0001_0000, 0);
    repeat (3) @(negedge clk);
    check("R5 idle before random", {31'b0, msgValid}, 0);

    // R5 random entries and pins
    for (int it = 0; it < 20; it++) begin
      int          pin;
      logic [7:0]  vec;
      logic [7:0]  dst;
      logic [2:0]  mode;
      logic        logical;
      pin     = int'($urandom_range(0, 23));
      vec     = 8'($urandom_range(16, 254));
      dst     = 8'($urandom);
      logical = 1'($urandom);
      case ($urandom_range(0, 2))
        0:       mode = 3'h0;
        1:       mode = 3'h1;
        default: mode = 3'h4;
      endcase
      entryWrite(pin, loWord(vec, mode, logical, 0, 0, 0, 0, 0), {dst, 24'b0});
      @(negedge clk); irqPins[pin] = 1'b1;
      waitValid(8, seen);
      check("R5 random offered", {31'b0, seen}, 1);
      check("R5 random fields",
            {13'b0, msgVector, msgDelMode, msgDestLogical, msgDest},
            {13'b0, vec, mode, logical, dst});
      accept();
      @(negedge clk); irqPins[pin] = 1'b0;
      entryWrite(pin, 32'h0001_0000, 0);
      check("R10 one message per handshake", {31'b0, msgValid}, 0);
    end

    summary();
  end

endmodule